// File: doc/BRIEF.md
# Privilege-Checked CSR Access Unit

This block is the control-and-status register port of a small processor that runs in machine and user privilege. Each cycle it can take one request: a 12-bit register address, a read or write command, write data and the privilege the core is running at. It answers in the same cycle with read data and an error flag. A write that is not flagged updates the target register at the next rising clock edge.

The status, interrupt-enable and interrupt-pending registers each exist once. Each has a machine address and a user address, and both point at the same storage. The address used picks a mask, and that mask decides which bits are visible and which are writable. Reads of the enable and pending registers are further filtered by the interrupt delegation register. The machine timer pending bit is owned by a hardware input and cannot be changed by software. The block also returns a strapped hart identifier, a fixed ISA description word and a free-running cycle counter.

Top module: `csr_access_unit`

## Requirements
- R1: After reset every writable register and the cycle counter hold 0, so reads of status (0x300), enable (0x304) and scratch (0x340) return 0 with no error.
- R2: When the current privilege (U=0, M=3) is below the privilege in address bits [9:8], the access is flagged with err=1, reads return 0 and a write changes nothing.
- R3: Status through 0x300 reads as the stored value AND 0x807FF9DD. A write there replaces only the bits set in that mask.
- R4: Status through 0x000 reads as the stored value AND 0x80000011. A write there replaces only those bits and keeps every machine-only bit.
- R5: Enable (0x304/0x004) and pending (0x344/0x044) writes change only the bits in mask 0xBBB for the machine address and 0x111 for the user address. Bits 12 and above always read 0.
- R6: Reads of the enable and pending registers return the stored value AND the interrupt delegation register at 0x303.
- R7: Pending bit 7 follows the timer input, sampled on every clock edge. No software write to the pending register sets or clears it.
- R8: The ISA word at 0x301 reads as the parameter value. A write to it is flagged as an error and has no effect.
- R9: 0xF14 returns the hart ID input. A write to any address whose bits [11:10] are 2'b11 (0xCxx, 0xFxx) is flagged as an error.
- R10: An address that maps to no register (for example 0x100 or 0x7B0) gives err=1 and read data 0.
- R11: The registers at 0x302, 0x303, 0x305, 0x340, 0x341, 0x342 and 0x343 are full-width read/write.
- R12: The cycle counter rises by one each cycle. A write to 0xB00 loads it. 0xC00 reads the same counter from user privilege and is read-only.
- R13: err and read data depend only on the inputs and register state of the current cycle. A write accepted in one cycle is visible to a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | XLEN | Write data |
| cur_priv | input | 2 | Current privilege, 0 = user, 3 = machine |
| hart_id | input | XLEN | Strapped hart identifier |
| timer_irq | input | 1 | Machine timer interrupt level |
| rd_data | output | XLEN | Read data, 0 on error or when idle |
| err | output | 1 | Access rejected |

## Verification
The hardest case to reach from the ports is a clash on pending bit 7. The timer input holds the bit high while software writes zero to the whole pending register. The result is only visible when the delegation register lets bit 7 through on the read path. The stimulus therefore first opens the delegation register to all ones, fills the pending register with ones while the timer is low, then raises the timer for an idle cycle and issues a clearing write while it stays high. Reads then show bit 7 set alone, and cleared once the timer falls. A similar sequence checks that the two status aliases share storage: it writes through one address and reads back through the other.

// File: rtl/csr_access_pkg.sv
// Package: shared constants, selector type and mask functions for the CSR
// access unit. Assumes only user (0) and machine (3) privilege are used.
package csr_access_pkg;

    localparam logic [1:0] PRIV_USER    = 2'd0;
    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    localparam int IRQ_W     = 12;
    localparam int TIMER_BIT = 7;

    // Address map
    localparam logic [11:0] A_STATUS_M  = 12'h300;
    localparam logic [11:0] A_STATUS_U  = 12'h000;
    localparam logic [11:0] A_IE_M      = 12'h304;
    localparam logic [11:0] A_IE_U      = 12'h004;
    localparam logic [11:0] A_IP_M      = 12'h344;
    localparam logic [11:0] A_IP_U      = 12'h044;
    localparam logic [11:0] A_ISA       = 12'h301;
    localparam logic [11:0] A_EXC_DELEG = 12'h302;
    localparam logic [11:0] A_IRQ_DELEG = 12'h303;
    localparam logic [11:0] A_VECTOR    = 12'h305;
    localparam logic [11:0] A_SCRATCH   = 12'h340;
    localparam logic [11:0] A_RET_PC    = 12'h341;
    localparam logic [11:0] A_CAUSE     = 12'h342;
    localparam logic [11:0] A_FAULT_VAL = 12'h343;
    localparam logic [11:0] A_HART      = 12'hF14;
    localparam logic [11:0] A_CYCLE_M   = 12'hB00;
    localparam logic [11:0] A_CYCLE_U   = 12'hC00;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_IE,
        SEL_IP,
        SEL_ISA,
        SEL_HART,
        SEL_CYCLE,
        SEL_EXC_DELEG,
        SEL_IRQ_DELEG,
        SEL_VECTOR,
        SEL_SCRATCH,
        SEL_RET_PC,
        SEL_CAUSE,
        SEL_FAULT_VAL
    } csr_sel_e;

    // Plain full-width read/write registers, indexed 0..NUM_PLAIN-1
    localparam int NUM_PLAIN     = 7;
    localparam int PLAIN_IRQ_DEL = 1;

    // Map a plain-register index to its selector
    function automatic csr_sel_e plain_sel(input int idx);
        case (idx)
            0:       return SEL_EXC_DELEG;
            1:       return SEL_IRQ_DELEG;
            2:       return SEL_VECTOR;
            3:       return SEL_SCRATCH;
            4:       return SEL_RET_PC;
            5:       return SEL_CAUSE;
            default: return SEL_FAULT_VAL;
        endcase
    endfunction

    // Visible/writable status bits for the alias privilege
    function automatic logic [31:0] status_mask(input logic [1:0] alias_priv);
        return (alias_priv == PRIV_USER) ? 32'h8000_0011 : 32'h807F_F9DD;
    endfunction

    // Writable interrupt bits for the alias privilege
    function automatic logic [IRQ_W-1:0] irq_mask(input logic [1:0] alias_priv);
        return (alias_priv == PRIV_USER) ? 12'h111 : 12'hBBB;
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
// Address decoder and access checker. Turns the address into a register
// selector, and flags privilege faults, unmapped addresses and writes to
// read-only registers. Purely combinational; assumes a single request per cycle.
module csr_addr_decode
    import csr_access_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [1:0]  cur_priv,
    output csr_sel_e    sel,
    output logic [1:0]  alias_priv,
    output logic        err,
    output logic        wr_en
);

    logic priv_fault;
    logic read_only;

    // Map the address onto a register selector
    always_comb begin
        case (req_addr)
            A_STATUS_M, A_STATUS_U: sel = SEL_STATUS;
            A_IE_M, A_IE_U:         sel = SEL_IE;
            A_IP_M, A_IP_U:         sel = SEL_IP;
            A_ISA:                  sel = SEL_ISA;
            A_EXC_DELEG:            sel = SEL_EXC_DELEG;
            A_IRQ_DELEG:            sel = SEL_IRQ_DELEG;
            A_VECTOR:               sel = SEL_VECTOR;
            A_SCRATCH:              sel = SEL_SCRATCH;
            A_RET_PC:               sel = SEL_RET_PC;
            A_CAUSE:                sel = SEL_CAUSE;
            A_FAULT_VAL:            sel = SEL_FAULT_VAL;
            A_HART:                 sel = SEL_HART;
            A_CYCLE_M, A_CYCLE_U:   sel = SEL_CYCLE;
            default:                sel = SEL_NONE;
        endcase
    end

    // Judge whether the access is allowed
    always_comb begin
        alias_priv = req_addr[9:8];
        priv_fault = cur_priv < req_addr[9:8];
        read_only  = (req_addr[11:10] == 2'b11) || (sel == SEL_ISA);
        err        = req_valid &&
                     ((sel == SEL_NONE) || priv_fault || (req_write && read_only));
        wr_en      = req_valid && req_write && !err;
    end

endmodule

// File: rtl/csr_state_regs.sv
// Register storage: the shared status, enable and pending registers with
// per-alias write masks, and the plain full-width registers. Writes land on
// the clock edge after an accepted request. Assumes XLEN >= 32.
module csr_state_regs
    import csr_access_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  csr_sel_e                       sel,
    input  logic [1:0]                     alias_priv,
    input  logic [XLEN-1:0]                wdata,
    input  logic                           timer_irq,
    output logic [XLEN-1:0]                status_q,
    output logic [IRQ_W-1:0]               ie_q,
    output logic [IRQ_W-1:0]               ip_q,
    output logic [NUM_PLAIN-1:0][XLEN-1:0] plain_q
);

    localparam logic [IRQ_W-1:0] TIMER_ONLY = IRQ_W'(1) << TIMER_BIT;

    logic [XLEN-1:0]  smask;
    logic [IRQ_W-1:0] imask;
    logic [IRQ_W-1:0] ip_sw_mask;
    logic [IRQ_W-1:0] ip_d;

    // Masks chosen by the privilege encoded in the address
    always_comb begin
        smask      = XLEN'(status_mask(alias_priv));
        imask      = irq_mask(alias_priv);
        ip_sw_mask = imask & ~TIMER_ONLY;
    end

    // Status register: only masked bits move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (wr_en && sel == SEL_STATUS) begin
            status_q <= (status_q & ~smask) | (wdata & smask);
        end
    end

    // Interrupt enable register: only masked bits move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (wr_en && sel == SEL_IE) begin
            ie_q <= (ie_q & ~imask) | (wdata[IRQ_W-1:0] & imask);
        end
    end

    // Next pending value: software bits, then timer bit from hardware
    always_comb begin
        ip_d = ip_q;
        if (wr_en && sel == SEL_IP) begin
            ip_d = (ip_q & ~ip_sw_mask) | (wdata[IRQ_W-1:0] & ip_sw_mask);
        end
        ip_d[TIMER_BIT] = timer_irq;
    end

    // Interrupt pending register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= '0;
        end else begin
            ip_q <= ip_d;
        end
    end

    // Plain full-width registers, one per selector
    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        localparam csr_sel_e MY_SEL = plain_sel(g);
        // Load on an accepted write to this register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                plain_q[g] <= '0;
            end else if (wr_en && sel == MY_SEL) begin
                plain_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/csr_cycle_counter.sv
// Free-running cycle counter with a synchronous load. Wraps at its width.
module csr_cycle_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count
);

    // Count up every cycle, or take the loaded value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else begin
            count <= count + WIDTH'(1);
        end
    end

endmodule

// File: rtl/csr_read_mux.sv
// Read data multiplexer. Applies the alias status mask and the delegation
// filter to enable/pending reads. Returns 0 on error or when idle.
module csr_read_mux
    import csr_access_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                           req_valid,
    input  logic                           err,
    input  csr_sel_e                       sel,
    input  logic [1:0]                     alias_priv,
    input  logic [XLEN-1:0]                status_q,
    input  logic [IRQ_W-1:0]               ie_q,
    input  logic [IRQ_W-1:0]               ip_q,
    input  logic [NUM_PLAIN-1:0][XLEN-1:0] plain_q,
    input  logic [XLEN-1:0]                isa_value,
    input  logic [XLEN-1:0]                hart_id,
    input  logic [XLEN-1:0]                cycle_count,
    output logic [XLEN-1:0]                rd_data
);

    logic [XLEN-1:0] deleg;
    logic [XLEN-1:0] value;

    // Pick the selected register and shape it for the alias
    always_comb begin
        deleg = plain_q[PLAIN_IRQ_DEL];
        value = '0;
        case (sel)
            SEL_STATUS: value = status_q & XLEN'(status_mask(alias_priv));
            SEL_IE:     value = XLEN'(ie_q) & deleg;
            SEL_IP:     value = XLEN'(ip_q) & deleg;
            SEL_ISA:    value = isa_value;
            SEL_HART:   value = hart_id;
            SEL_CYCLE:  value = cycle_count;
            default: begin
                for (int i = 0; i < NUM_PLAIN; i++) begin
                    if (sel == plain_sel(i)) value = plain_q[i];
                end
            end
        endcase
        rd_data = (req_valid && !err) ? value : '0;
    end

endmodule

// File: rtl/csr_access_unit.sv
// Top level of the privilege-checked CSR access unit. Assumes the core
// presents one request per cycle and consumes the response in that cycle.
module csr_access_unit
    import csr_access_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] ISA_VALUE = XLEN'(32'h4010_1104)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [11:0]     req_addr,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] hart_id,
    input  logic            timer_irq,
    output logic [XLEN-1:0] rd_data,
    output logic            err
);

    csr_sel_e                       sel;
    logic [1:0]                     alias_priv;
    logic                           wr_en;
    logic [XLEN-1:0]                status_q;
    logic [IRQ_W-1:0]               ie_q;
    logic [IRQ_W-1:0]               ip_q;
    logic [NUM_PLAIN-1:0][XLEN-1:0] plain_q;
    logic [XLEN-1:0]                cycle_count;
    logic                           cycle_load;

    csr_addr_decode u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .cur_priv   (cur_priv),
        .sel        (sel),
        .alias_priv (alias_priv),
        .err        (err),
        .wr_en      (wr_en)
    );

    csr_state_regs #(.XLEN(XLEN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel        (sel),
        .alias_priv (alias_priv),
        .wdata      (req_wdata),
        .timer_irq  (timer_irq),
        .status_q   (status_q),
        .ie_q       (ie_q),
        .ip_q       (ip_q),
        .plain_q    (plain_q)
    );

    // Counter loads on an accepted write to its machine address
    always_comb cycle_load = wr_en && (sel == SEL_CYCLE);

    csr_cycle_counter #(.WIDTH(XLEN)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cycle_load),
        .load_val (req_wdata),
        .count    (cycle_count)
    );

    csr_read_mux #(.XLEN(XLEN)) u_rmux (
        .req_valid   (req_valid),
        .err         (err),
        .sel         (sel),
        .alias_priv  (alias_priv),
        .status_q    (status_q),
        .ie_q        (ie_q),
        .ip_q        (ip_q),
        .plain_q     (plain_q),
        .isa_value   (ISA_VALUE),
        .hart_id     (hart_id),
        .cycle_count (cycle_count),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/csr_access_checker.sv
// Port-level properties of the CSR access unit, bound to every instance.
module csr_access_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [11:0]     req_addr,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] rd_data,
    input logic            err
);

    assert_priv_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cur_priv < req_addr[9:8])) |-> (err && rd_data == '0));

    assert_status_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h300) |-> ((rd_data & ~XLEN'(32'h807F_F9DD)) == '0));

    assert_user_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h000) |-> ((rd_data & ~XLEN'(32'h8000_0011)) == '0));

    assert_irq_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr == 12'h304 || req_addr == 12'h344)) |-> (rd_data[XLEN-1:12] == '0));

    assert_isa_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 12'h301) |-> err);

    assert_readonly_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[11:10] == 2'b11) |-> err);

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_data == '0 && req_valid));

endmodule

bind csr_access_unit csr_access_checker #(.XLEN(XLEN)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .cur_priv  (cur_priv),
    .rd_data   (rd_data),
    .err       (err)
);

// File: tb/tb_csr_access_unit.sv
module tb_csr_access_unit;

    localparam int          XLEN   = 32;
    localparam logic [31:0] ISA    = 32'h4010_1104;
    localparam logic [31:0] HART   = 32'h0000_0005;
    localparam logic [1:0]  PU     = 2'd0;
    localparam logic [1:0]  PM     = 2'd3;

    typedef struct {
        logic        exp_err;
        logic        chk_rd;
        logic [31:0] exp_rd;
        string       tag;
    } exp_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_wdata = '0;
    logic [1:0]      cur_priv = PM;
    logic [XLEN-1:0] hart_id = HART;
    logic            timer_irq = 1'b0;
    logic [XLEN-1:0] rd_data;
    logic            err;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    exp_item_t sb_q[$];
    event sample_ev;

    always #10 clk = ~clk;

    csr_access_unit #(.XLEN(XLEN), .ISA_VALUE(ISA)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cur_priv(cur_priv),
        .hart_id(hart_id), .timer_irq(timer_irq), .rd_data(rd_data), .err(err)
    );

    // Driver: one request per cycle, expectation pushed to the scoreboard
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                          input logic [1:0] pr, input logic e_err, input logic chk,
                          input logic [31:0] e_rd, input string tag);
        exp_item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; cur_priv = pr;
        #5;
        it.exp_err = e_err; it.chk_rd = chk; it.exp_rd = e_rd; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] pr, input logic [31:0] e, input string tag);
        access(1'b0, a, 32'h0, pr, 1'b0, 1'b1, e, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] pr, input string tag);
        access(1'b1, a, d, pr, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic set_timer(input logic v);
        @(negedge clk);
        timer_irq = v;
    endtask

    // Monitor: pop the expected item and compare against the outputs
    initial begin
        forever begin
            exp_item_t it;
            @(sample_ev);
            it = sb_q.pop_front();
            compared++;
            if (err !== it.exp_err || (it.chk_rd && rd_data !== it.exp_rd)) begin
                mismatched++;
                $display("FAIL %s: err=%0b rd=%h expected err=%0b rd=%h",
                         it.tag, err, rd_data, it.exp_err, it.exp_rd);
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h300, PM, 32'h0, "R1 status after reset");
        rd(12'h304, PM, 32'h0, "R1 enable after reset");
        rd(12'h340, PM, 32'h0, "R1 scratch after reset");

        // R3 machine status mask
        wr(12'h300, 32'hFFFF_FFFF, PM, "R3 status write");
        rd(12'h300, PM, 32'h807F_F9DD, "R3 status masked read");
        // R4 user alias sees only its bits, and writes only those
        rd(12'h000, PU, 32'h8000_0011, "R4 user status read");
        wr(12'h000, 32'h0, PU, "R4 user status clear");
        rd(12'h300, PM, 32'h007F_F9CC, "R4 machine bits kept");

        // R2 privilege fault
        access(1'b0, 12'h300, 32'h0, PU, 1'b1, 1'b1, 32'h0, "R2 user reads machine status");
        access(1'b1, 12'h340, 32'h1234, PU, 1'b1, 1'b0, 32'h0, "R2 user writes scratch");
        rd(12'h340, PM, 32'h0, "R2 blocked write left scratch");

        // R11 delegation as plain register
        wr(12'h303, 32'hFFFF_FFFF, PM, "R11 delegation write");
        rd(12'h303, PM, 32'hFFFF_FFFF, "R11 delegation read");

        // R5 enable write masks
        wr(12'h304, 32'hFFFF_FFFF, PM, "R5 enable machine write");
        rd(12'h304, PM, 32'h0000_0BBB, "R5 enable machine mask");
        wr(12'h004, 32'h0, PU, "R5 enable user clear");
        rd(12'h304, PM, 32'h0000_0AAA, "R5 enable user mask");

        // R6 delegation filter on reads
        wr(12'h303, 32'h0000_00F0, PM, "R6 narrow delegation");
        rd(12'h304, PM, 32'h0000_00A0, "R6 enable filtered");
        rd(12'h004, PU, 32'h0000_00A0, "R6 user enable filtered");
        wr(12'h303, 32'hFFFF_FFFF, PM, "R6 reopen delegation");

        // R7 timer bit owned by hardware
        wr(12'h344, 32'hFFFF_FFFF, PM, "R7 pending write ones");
        rd(12'h344, PM, 32'h0000_0B3B, "R7 bit7 not set by software");
        set_timer(1'b1);
        rd(12'h344, PM, 32'h0000_0BBB, "R7 bit7 follows timer");
        wr(12'h344, 32'h0, PM, "R7 pending clear with timer high");
        rd(12'h344, PM, 32'h0000_0080, "R7 bit7 not cleared by software");
        set_timer(1'b0);
        rd(12'h044, PU, 32'h0000_0000, "R7 bit7 falls with timer");

        // R8 ISA word
        rd(12'h301, PM, ISA, "R8 isa read");
        access(1'b1, 12'h301, 32'h0, PM, 1'b1, 1'b0, 32'h0, "R8 isa write rejected");
        rd(12'h301, PM, ISA, "R8 isa unchanged");

        // R9 hart id and read-only space
        rd(12'hF14, PM, HART, "R9 hart id read");
        access(1'b1, 12'hF14, 32'h0, PM, 1'b1, 1'b0, 32'h0, "R9 hart id write rejected");
        access(1'b1, 12'hC00, 32'h0, PM, 1'b1, 1'b0, 32'h0, "R9 user counter write rejected");

        // R10 unmapped
        access(1'b0, 12'h7B0, 32'h0, PM, 1'b1, 1'b1, 32'h0, "R10 unmapped debug");
        access(1'b0, 12'h100, 32'h0, PM, 1'b1, 1'b1, 32'h0, "R10 unmapped supervisor");

        // R11 plain registers
        wr(12'h305, 32'hA5A5_A5A5, PM, "R11 vector write");
        wr(12'h342, 32'h8000_000B, PM, "R11 cause write");
        wr(12'h302, 32'h0000_F00F, PM, "R11 exc deleg write");
        rd(12'h305, PM, 32'hA5A5_A5A5, "R11 vector read");
        rd(12'h342, PM, 32'h8000_000B, "R11 cause read");
        rd(12'h302, PM, 32'h0000_F00F, "R11 exc deleg read");

        // R12 cycle counter
        wr(12'hB00, 32'd100, PM, "R12 counter load");
        rd(12'hB00, PM, 32'd100, "R12 counter loaded");
        rd(12'hC00, PU, 32'd101, "R12 counter increments, user alias");

        // R13 write visible on the next cycle
        wr(12'h341, 32'h0000_2468, PM, "R13 write");
        rd(12'h341, PM, 32'h0000_2468, "R13 next-cycle read");

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL scoreboard: %0d left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule